// File: doc/BRIEF.md
# I2C Register-Pair Target with Commit-on-STOP

This block is the serial control port of a larger chip. It watches the two I2C lines with a fast system clock. Both lines are synchronized and filtered before use. The block finds START, repeated START and STOP conditions on the filtered lines and responds only to its own fixed 7-bit device address. The bus drive is open-drain: the block only ever pulls SDA low, through an output enable.

A write transaction carries any number of (register index, value) byte pairs after the address byte. Each completed pair is parked in a shadow copy of its register, and a per-register pending flag is set. Nothing reaches the register outputs until the master sends STOP. At STOP, every pending register is updated in the same cycle and a one-cycle commit strobe marks the event.

A read transaction returns an 8-bit status value supplied by the surrounding chip. There is no register pointer on the read side.

Top module: `i2c_pair_slave`

## Requirements
- R1: SCL and SDA are each passed through a two-stage synchronizer and a stability filter. A level change that lasts fewer than FILT_LEN clock cycles is ignored, so it creates no extra bit and no false START or STOP.
- R2: A falling SDA while SCL is high is a START; a second START before STOP is a repeated START. A rising SDA while SCL is high is a STOP, and after it the block is idle.
- R3: The address byte is the device address DEV_ADDR in bits 7..1 (default 7'b0110100) plus a read/write bit in bit 0, where 0 means write, so the defaults are 0x68 for write and 0x69 for read. Every byte is shifted most significant bit first, and a ninth clock carries the acknowledge.
- R4: In a write, the block acknowledges the address byte, every register-index byte and every data byte by pulling SDA low (sda_oe = 1) for the whole ninth clock. sda_oe never changes while SCL stays high.
- R5: After a write address, the bytes alternate between register index and data value. Any number of pairs may follow.
- R6: Register outputs are unchanged until STOP. At STOP, all pending registers update together and commit_o pulses for exactly one cycle. If a register was written more than once, the last value sent wins. The output byte for register i is regs_o[8*i+7 : 8*i].
- R7: A register index with no data byte before STOP is discarded. An index of NREG or above is acknowledged but writes nothing. A STOP with no in-range pair pending gives no commit_o pulse.
- R8: In a read, the block acknowledges the read address. It then sends status_i MSB first, taking the value at the falling SCL edge that ends the previous acknowledge, and releases SDA after the eighth bit. A master ACK causes a fresh status byte to be sent. A master NACK makes the block release the bus until the next START or STOP.
- R9: On an address mismatch the block does not acknowledge and drives nothing until the next START or STOP. A repeated START restarts address matching.
- R10: During and after reset, sda_oe and commit_o are 0 and all register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| status_i | input | 8 | Status value returned by read transactions |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | Committed register values, register i in bits 8*i+7:8*i |
| commit_o | output | 1 | One-cycle pulse when a STOP applies pending writes |

## Verification
The bench builds the block with its defaults: DEV_ADDR = 7'h34, NREG = 8 and FILT_LEN = 3. With eight registers, indices 8 and 0xFF land just outside the implemented range, so the acknowledge-but-ignore path is reachable with ordinary byte values. A filter length of three lets a two-cycle pulse on either line probe the edge of glitch rejection. The bench injects such a pulse on SCL while it is low, which would otherwise add a spurious bit, and on SDA while SCL is high, which would otherwise form a false START or STOP. The quarter-bit spacing of the modelled master is wide enough that the filter latency never crosses an SCL edge.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } bus_state_e;

endpackage

// File: rtl/i2cp_filter.sv
module i2cp_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic q
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2, q_r, q_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    q_n   = q_r;
    if (s2 == q_r) begin
      cnt_n = '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      q_n   = s2;
      cnt_n = '0;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      q_r <= 1'b1;
      cnt <= '0;
    end else begin
      s1  <= raw;
      s2  <= s1;
      q_r <= q_n;
      cnt <= cnt_n;
    end
  end

  assign q = q_r;

  // R1: the filtered level only moves to a value the synchronizer had settled on
  assert_filter_settle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r != $past(q_r)) |-> ($past(s2) == q_r));

endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
  import i2cp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] status_in,
  output logic       sda_oe,
  output logic       pair_we,
  output logic [7:0] pair_addr,
  output logic [7:0] pair_data
);
  bus_state_e state, state_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] sr, sr_n;
  logic [7:0] idx, idx_n;
  logic       phase, phase_n;
  logic       rd, rd_n;
  logic       oe, oe_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sr_n    = sr;
    idx_n   = idx;
    phase_n = phase;
    rd_n    = rd;
    oe_n    = oe;
    pair_we = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sr_n  = {sr[6:0], sda_f};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (sr[7:1] == DEV_ADDR) begin
              state_n = ST_ADDR_ACK;
              oe_n    = 1'b1;
              rd_n    = sr[0];
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (rd) begin
              state_n = ST_RD;
              sr_n    = status_in;
              oe_n    = ~status_in[7];
            end else begin
              state_n = ST_WR;
              oe_n    = 1'b0;
              phase_n = 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sr_n  = {sr[6:0], sda_f};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            state_n = ST_WR_ACK;
            oe_n    = 1'b1;
            phase_n = ~phase;
            if (!phase) idx_n = sr;
            else        pair_we = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_n = ST_WR;
            oe_n    = 1'b0;
            cnt_n   = 4'd0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state_n = ST_RD_ACK;
              oe_n    = 1'b0;
            end else begin
              sr_n = {sr[6:0], 1'b0};
              oe_n = ~sr[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_f) begin
            state_n = ST_SKIP;
          end else if (scl_fall) begin
            state_n = ST_RD;
            sr_n    = status_in;
            oe_n    = ~status_in[7];
            cnt_n   = 4'd0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= 4'd0;
      sr    <= 8'd0;
      idx   <= 8'd0;
      phase <= 1'b0;
      rd    <= 1'b0;
      oe    <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      sr    <= sr_n;
      idx   <= idx_n;
      phase <= phase_n;
      rd    <= rd_n;
      oe    <= oe_n;
    end
  end

  assign sda_oe    = oe;
  assign pair_addr = idx;
  assign pair_data = sr;

  // R3: a byte never holds more than eight bits plus the acknowledge slot
  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

  // R4: the drive does not move while SCL stays high, except after a bus condition
  assert_ack_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> (oe == $past(oe)));

  // R9: an ignored transfer never drives SDA
  assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !oe);

endmodule

// File: rtl/i2cp_regbank.sv
module i2cp_regbank #(
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pair_we,
  input  logic [7:0]           pair_addr,
  input  logic [7:0]           pair_data,
  input  logic                 stop_det,
  output logic [NREG-1:0][7:0] reg_q,
  output logic                 commit_stb
);
  localparam int         AW     = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [8:0] NREG_W = 9'(NREG);

  logic                 in_range;
  logic [NREG-1:0]      pend, pend_n;
  logic [NREG-1:0][7:0] shadow, shadow_n, reg_n;
  logic                 stb_n;

  assign in_range = ({1'b0, pair_addr} < NREG_W);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = pair_we && in_range && (pair_addr[AW-1:0] == AW'(i));

    always_comb begin
      shadow_n[i] = shadow[i];
      pend_n[i]   = pend[i];
      reg_n[i]    = reg_q[i];
      if (stop_det) begin
        pend_n[i] = 1'b0;
        if (pend[i]) reg_n[i] = shadow[i];
      end else if (hit) begin
        shadow_n[i] = pair_data;
        pend_n[i]   = 1'b1;
      end
    end
  end

  assign stb_n = stop_det && (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      shadow     <= '0;
      reg_q      <= '0;
      commit_stb <= 1'b0;
    end else begin
      pend       <= pend_n;
      shadow     <= shadow_n;
      reg_q      <= reg_n;
      commit_stb <= stb_n;
    end
  end

  // R6: a commit pulse only follows a STOP
  assert_commit_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(stop_det));

  // R6: register outputs move only together with the commit pulse
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q != $past(reg_q)) |-> commit_stb);

  // R7: an out-of-range pair leaves the pending set untouched
  assert_range_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_we && !in_range && !stop_det) |=> (pend == $past(pend)));

endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         NREG     = 8,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [7:0]        status_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o,
  output logic              commit_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cp_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .raw  (raw[g]),
      .q    (filt[g])
    );
  end

  logic scl_rise, scl_fall, start_det, stop_det;

  i2cp_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_f    (filt[0]),
    .sda_f    (filt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  logic       pair_we;
  logic [7:0] pair_addr, pair_data;

  i2cp_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_f    (filt[0]),
    .sda_f    (filt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .status_in(status_i),
    .sda_oe   (sda_oe),
    .pair_we  (pair_we),
    .pair_addr(pair_addr),
    .pair_data(pair_data)
  );

  logic [NREG-1:0][7:0] reg_q;

  i2cp_regbank #(.NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pair_we   (pair_we),
    .pair_addr (pair_addr),
    .pair_data (pair_data),
    .stop_det  (stop_det),
    .reg_q     (reg_q),
    .commit_stb(commit_o)
  );

  assign regs_o = reg_q;

endmodule

// File: tb/i2c_pair_slave_test.sv
module i2c_pair_slave_test;
  localparam int CLK_PER = 10;
  localparam int Q       = 20;
  localparam int NR      = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_m, sda_m;
  logic [7:0]    status_i;
  logic          sda_oe, commit_o;
  logic [NR*8-1:0] regs_o;
  logic          bus_sda;

  assign bus_sda = sda_m & ~sda_oe;

  always #(CLK_PER/2) clk = ~clk;

  i2c_pair_slave uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (bus_sda),
    .status_i(status_i),
    .sda_oe  (sda_oe),
    .regs_o  (regs_o),
    .commit_o(commit_o)
  );

  int checks = 0;
  int bad    = 0;
  int stb_cnt = 0;
  int exp_stb = 0;
  logic [7:0] exp_regs [NR];
  bit glitch_en = 1'b0;

  always @(posedge clk) if (rst_n && commit_o) stb_cnt++;

  // each entry: register index in [15:8], data value in [7:0]
  localparam logic [15:0] VEC [8] = '{
    16'h00A5, 16'h075A, 16'h0300, 16'h03FF,
    16'h0877, 16'hFF12, 16'h0180, 16'h0642
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  // returns 1 if SDA was low at both samples of the ninth clock high, 0 if high at both, else 2
  task automatic send_byte(input logic [7:0] b, output int ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      if (glitch_en && i == 2) begin
        sda_m = ~b[i]; repeat (2) @(negedge clk); sda_m = b[i];
      end
      wq();
      scl_m = 1'b0;
      if (glitch_en && i == 4) begin
        repeat (5) @(negedge clk);
        scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0;
      end
      wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; repeat (2) @(negedge clk); s1 = bus_sda;
    wq(); s2 = bus_sda;
    scl_m = 1'b0; wq();
    ack = (!s1 && !s2) ? 1 : ((s1 && s2) ? 0 : 2);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = bus_sda; wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic master_ack(input logic nack, output logic line);
    sda_m = nack; wq(); scl_m = 1'b1; wq(); line = bus_sda; wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] reg_at(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++) chk(tag, {24'd0, reg_at(i)}, {24'd0, exp_regs[i]});
  endtask

  int a;
  logic [7:0] rb;
  logic ln;

  initial begin
    for (int i = 0; i < NR; i++) exp_regs[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; status_i = 8'h00;
    repeat (10) @(negedge clk);
    chk("R10 sda_oe in reset", {31'd0, sda_oe}, 0);
    chk("R10 commit in reset", {31'd0, commit_o}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 regs after reset", regs_o[31:0] | regs_o[63:32], 0);
    chk("R10 sda_oe after reset", {31'd0, sda_oe}, 0);

    // table of single-pair writes: R3 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [7:0] ri, dv;
      ri = VEC[v][15:8]; dv = VEC[v][7:0];
      bus_start();
      send_byte(8'h68, a); chk("R4 address ack", a, 1);
      send_byte(ri, a);    chk("R4 index ack (R7 out of range too)", a, 1);
      send_byte(dv, a);    chk("R4 data ack", a, 1);
      check_regs("R6 no update before STOP");
      bus_stop();
      if (ri < NR) begin
        exp_regs[ri] = dv; exp_stb++;
      end
      check_regs("R3 R7 value after STOP");
      chk("R6 R7 commit count", stb_cnt, exp_stb);
    end

    // R5 R6: several pairs, repeated index, last wins
    bus_start();
    send_byte(8'h68, a); chk("R4 address ack", a, 1);
    send_byte(8'h02, a); send_byte(8'h11, a);
    send_byte(8'h05, a); send_byte(8'h22, a);
    send_byte(8'h02, a); send_byte(8'h33, a); chk("R4 last data ack", a, 1);
    check_regs("R6 held until STOP");
    chk("R6 no strobe before STOP", stb_cnt, exp_stb);
    bus_stop();
    exp_regs[2] = 8'h33; exp_regs[5] = 8'h22; exp_stb++;
    check_regs("R5 R6 multi-pair commit");
    chk("R6 single strobe", stb_cnt, exp_stb);

    // R7: unpaired trailing index discarded
    bus_start();
    send_byte(8'h68, a);
    send_byte(8'h04, a); send_byte(8'h44, a);
    send_byte(8'h06, a); chk("R4 unpaired index ack", a, 1);
    bus_stop();
    exp_regs[4] = 8'h44; exp_stb++;
    check_regs("R7 unpaired index discarded");
    chk("R7 strobe count", stb_cnt, exp_stb);

    // R7: only an unpaired index, no strobe
    bus_start();
    send_byte(8'h68, a); send_byte(8'h01, a);
    bus_stop();
    chk("R7 no strobe without pair", stb_cnt, exp_stb);

    // R9: wrong address ignored
    bus_start();
    send_byte(8'h6A, a); chk("R9 no ack wrong address", a, 0);
    send_byte(8'h01, a); chk("R9 no ack afterwards", a, 0);
    send_byte(8'h00, a); chk("R9 no ack data", a, 0);
    bus_stop();
    check_regs("R9 regs untouched");
    chk("R9 no strobe", stb_cnt, exp_stb);

    // R2 R9: repeated START restarts matching
    bus_start();
    send_byte(8'h50, a); chk("R9 mismatch", a, 0);
    bus_restart();
    send_byte(8'h68, a); chk("R2 ack after repeated START", a, 1);
    send_byte(8'h01, a); send_byte(8'hC3, a);
    bus_stop();
    exp_regs[1] = 8'hC3; exp_stb++;
    check_regs("R2 write after repeated START");

    // R8: read
    status_i = 8'hA6;
    bus_start();
    send_byte(8'h69, a); chk("R8 read address ack", a, 1);
    recv_byte(rb); chk("R8 first status byte", {24'd0, rb}, 32'hA6);
    status_i = 8'h3C;
    master_ack(1'b0, ln);
    recv_byte(rb); chk("R8 status after master ACK", {24'd0, rb}, 32'h3C);
    master_ack(1'b1, ln); chk("R8 SDA released at NACK", {31'd0, ln}, 1);
    chk("R8 no drive after NACK", {31'd0, sda_oe}, 0);
    bus_stop();
    chk("R8 read leaves regs", stb_cnt, exp_stb);

    // R1: glitches on SCL and SDA rejected
    glitch_en = 1'b1;
    bus_start();
    send_byte(8'h68, a); chk("R1 ack under glitches", a, 1);
    send_byte(8'h07, a); send_byte(8'h96, a); chk("R1 data ack", a, 1);
    glitch_en = 1'b0;
    bus_stop();
    exp_regs[7] = 8'h96; exp_stb++;
    check_regs("R1 glitch-free result");
    chk("R1 strobe count", stb_cnt, exp_stb);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule